// File: doc/BRIEF.md
# SD Host Command Issue Unit

This block is the register-side half of the command path in an SD host controller. Software writes a command argument and then a packed command word. The unit decodes that word into a response type, CRC and index check enables, and a data-present flag. If the inhibit bits allow it, the unit sends a one-cycle request to a card-side responder and sets the matching inhibit bits in a present-state register. The responder does the serial CMD-line work and is not part of this block.

When the responder answers, the unit does three things. It stores the response payload into four 32-bit response words. It clears command inhibit. It raises either response-complete or one or more error flags in a write-one-to-clear interrupt status register. A summary flag there reads as set whenever any error flag is set. A busy-type command or a data command keeps data inhibit set until the data side reports that it has finished.

Three self-clearing software reset bits abort the command path, the data path, or the whole unit. Each bit stays readable as set until its reset has run for a fixed number of cycles.

Top module: `sdh_cmd_unit`

## Requirements
- R1: After reset, every readable register reads zero and `req_valid` is low.
- R2: Writing the command word at offset 0x0C sends a request in the next cycle. In that request, `req_index` comes from bits 13:8, `req_rtype` from bits 1:0, and `req_arg` is the argument register at offset 0x08. The write sets present-state bit 0 (command inhibit). It also sets present-state bit 1 (data inhibit) when bit 5 (data present) is set or when the response type is 11 (short with busy). Present state is at offset 0x24.
- R3: A command write is ignored while command inhibit is set. A command that needs the data line is also ignored while data inhibit is set. An ignored write sends no request and leaves the stored command word (read at 0x0C) unchanged. A command that does not need the data line may still issue while data inhibit is set.
- R4: For a response of type 10 or 11 that has no error, word 0x10 takes payload bits 31:0. Words 0x14, 0x18 and 0x1C read zero. Status bit 0 sets and command inhibit clears. Status is at offset 0x30.
- R5: For type 01 (136-bit), the response words hold payload bits 127:8 in their bits 119:0, with word 0x10 as the low word. The top byte of word 0x1C reads zero.
- R6: A command of type 00 does not wait for the responder. Command inhibit clears, and status bit 0 sets, one cycle after the request.
- R7: A responder answer with errors sets status bits as follows: timeout sets bit 16; CRC error sets bit 17 only if command bit 3 was set; end-bit error sets bit 18; index mismatch sets bit 19 only if command bit 4 was set. A timeout suppresses the other three flags and leaves the response words unchanged. Bit 15 reads as the OR of bits 31:16. An answer that reports any error does not set bit 0. Command inhibit clears either way.
- R8: `dat_done` clears data inhibit and sets status bit 1 while data inhibit is set. It has no effect while data inhibit is clear.
- R9: Writing a one to status bits 0, 1 or 19:16 clears them. Bit 15 cannot be written.
- R10: Writing 1 to bit 0, 1 or 2 of offset 0x2C starts the all, command or data reset. The bit reads as set for RST_CYCLES cycles and then clears itself. A command reset clears command inhibit, discards a pending response and blocks command issue. A data reset clears data inhibit. The all reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | ADDR_W | Read byte offset |
| reg_rdata | output | 32 | Read data (combinational) |
| req_valid | output | 1 | One-cycle command request to the responder |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| req_rtype | output | 2 | Expected response type |
| rsp_valid | input | 1 | Responder answer strobe |
| rsp_payload | input | 128 | Response bits following the header byte |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_err | input | 1 | Response CRC mismatch |
| rsp_end_err | input | 1 | Bad end bit |
| rsp_idx_err | input | 1 | Echoed index mismatch |
| dat_done | input | 1 | Data transfer or busy phase finished |

## Verification
The embedded assertions check these properties on every cycle:
- a request lasts exactly one cycle and never leaves while command inhibit is already set;
- an error flag only appears right after a responder answer;
- data inhibit only falls after `dat_done` or a data-path reset;
- an active command reset always leaves command inhibit clear;
- each reset bit drops once its count expires;
- a long response never fills the top byte.

Only the directed scenarios can show the rest:
- the exact response word layout;
- CRC and index errors being masked by the command's check enables;
- timeout suppressing capture;
- the issue-gating differences between data and non-data commands;
- a late response after a command reset being discarded.

// File: rtl/sdh_cmd_pkg.sv
package sdh_cmd_pkg;
   localparam logic [7:0] OFS_ARG  = 8'h08;
   localparam logic [7:0] OFS_CMD  = 8'h0C;
   localparam logic [7:0] OFS_RSP0 = 8'h10;
   localparam logic [7:0] OFS_RSP1 = 8'h14;
   localparam logic [7:0] OFS_RSP2 = 8'h18;
   localparam logic [7:0] OFS_RSP3 = 8'h1C;
   localparam logic [7:0] OFS_PRES = 8'h24;
   localparam logic [7:0] OFS_SRST = 8'h2C;
   localparam logic [7:0] OFS_STAT = 8'h30;

   typedef enum logic [1:0] {
      RT_NONE  = 2'b00,
      RT_LONG  = 2'b01,
      RT_SHORT = 2'b10,
      RT_BUSY  = 2'b11
   } rtype_e;

   typedef struct packed {
      logic [5:0] index;
      rtype_e     rtype;
      logic       crc_chk;
      logic       idx_chk;
      logic       has_data;
      logic       needs_dat;
   } cmd_fields_t;
endpackage

// File: rtl/sdh_cmd_decode.sv
module sdh_cmd_decode
   import sdh_cmd_pkg::*;
(
   input  logic [15:0] cmd_word,
   output cmd_fields_t fields
);
   always_comb begin
      fields.index     = cmd_word[13:8];
      fields.rtype     = rtype_e'(cmd_word[1:0]);
      fields.crc_chk   = cmd_word[3];
      fields.idx_chk   = cmd_word[4];
      fields.has_data  = cmd_word[5];
      fields.needs_dat = cmd_word[5] | (cmd_word[1:0] == 2'b11);
   end
endmodule

// File: rtl/sdh_srst_seq.sv
module sdh_srst_seq #(
   parameter int NUM  = 3,
   parameter int HOLD = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr,
   input  logic [NUM-1:0] wdata,
   output logic [NUM-1:0] active
);
   localparam int CW = $clog2(HOLD + 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("sdh_srst_seq: HOLD must be at least 1");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_bit
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cnt <= '0;
         else if (wr && wdata[g])    cnt <= CW'(HOLD);
         else if (cnt != '0)         cnt <= cnt - CW'(1);
      end
      assign active[g] = (cnt != '0);

      assert_self_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == CW'(1) && !(wr && wdata[g])) |=> !active[g]);
   end
endmodule

// File: rtl/sdh_resp_store.sv
module sdh_resp_store #(
   parameter int WORD_W = 32,
   parameter int NWORDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     cap,
   input  logic                     long_mode,
   input  logic [WORD_W*NWORDS-1:0] payload,
   output logic [WORD_W*NWORDS-1:0] words
);
   localparam int TOT = WORD_W * NWORDS;

   if (TOT <= 8 || NWORDS < 2) begin : g_bad_size
      $error("sdh_resp_store: response storage too small");
   end

   logic [TOT-1:0] long_val, short_val;
   assign long_val  = {8'h00, payload[TOT-1:8]};
   assign short_val = {{(TOT-WORD_W){1'b0}}, payload[WORD_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   words <= '0;
      else if (clr) words <= '0;
      else if (cap) words <= long_mode ? long_val : short_val;
   end

   assert_long_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cap && long_mode && !clr) |-> (words[TOT-1:TOT-8] == 8'h00));
endmodule

// File: rtl/sdh_cmd_unit.sv
module sdh_cmd_unit
   import sdh_cmd_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [ADDR_W-1:0] reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              req_valid,
   output logic [5:0]        req_index,
   output logic [31:0]       req_arg,
   output logic [1:0]        req_rtype,
   input  logic              rsp_valid,
   input  logic [127:0]      rsp_payload,
   input  logic              rsp_timeout,
   input  logic              rsp_crc_err,
   input  logic              rsp_end_err,
   input  logic              rsp_idx_err,
   input  logic              dat_done
);
   localparam int NRST = 3;

   if (ADDR_W < 8) begin : g_bad_addr
      $error("sdh_cmd_unit: ADDR_W must cover offset 0x30");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   cmd_fields_t      dec;
   logic [NRST-1:0]  rst_act;
   logic [127:0]     rsp_words;
   logic             rst_all, rst_cmd_act, rst_dat_act;
   logic [31:0]      arg_q;
   logic [13:0]      cmd_q;
   logic             cmd_inhib, dat_inhib, waiting, pend_none;
   logic             crc_q, idx_q, long_q;
   logic [1:0]       stat_lo;
   logic [3:0]       stat_err;
   logic             launch, rsp_ok, any_err, cap;
   logic [3:0]       err_set;
   logic [1:0]       lo_set, lo_clr;
   logic [3:0]       err_clr;

   sdh_cmd_decode u_dec (.cmd_word(reg_wdata[15:0]), .fields(dec));

   sdh_srst_seq #(.NUM(NRST), .HOLD(RST_CYCLES)) u_srst (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_wr && hit(reg_addr, OFS_SRST)),
      .wdata(reg_wdata[NRST-1:0]),
      .active(rst_act)
   );

   assign rst_all     = rst_act[0];
   assign rst_cmd_act = rst_act[0] | rst_act[1];
   assign rst_dat_act = rst_act[0] | rst_act[2];

   assign launch = reg_wr && hit(reg_addr, OFS_CMD) && !cmd_inhib && !rst_cmd_act
                   && !(dec.needs_dat && (dat_inhib || rst_dat_act));

   assign rsp_ok     = rsp_valid && waiting && !rst_cmd_act;
   assign err_set[0] = rsp_ok && rsp_timeout;
   assign err_set[1] = rsp_ok && !rsp_timeout && rsp_crc_err && crc_q;
   assign err_set[2] = rsp_ok && !rsp_timeout && rsp_end_err;
   assign err_set[3] = rsp_ok && !rsp_timeout && rsp_idx_err && idx_q;
   assign any_err    = |err_set;
   assign cap        = rsp_ok && !rsp_timeout;

   assign lo_set[0] = pend_none || (rsp_ok && !any_err);
   assign lo_set[1] = dat_done && dat_inhib && !rst_dat_act;

   assign lo_clr  = (reg_wr && hit(reg_addr, OFS_STAT)) ? reg_wdata[1:0]   : 2'b00;
   assign err_clr = (reg_wr && hit(reg_addr, OFS_STAT)) ? reg_wdata[19:16] : 4'b0000;

   sdh_resp_store #(.WORD_W(32), .NWORDS(4)) u_store (
      .clk(clk), .rst_n(rst_n), .clr(rst_all), .cap(cap),
      .long_mode(long_q), .payload(rsp_payload), .words(rsp_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || rst_all) begin
         arg_q     <= '0;
         cmd_q     <= '0;
         cmd_inhib <= 1'b0;
         dat_inhib <= 1'b0;
         waiting   <= 1'b0;
         pend_none <= 1'b0;
         crc_q     <= 1'b0;
         idx_q     <= 1'b0;
         long_q    <= 1'b0;
         stat_lo   <= '0;
         stat_err  <= '0;
         req_valid <= 1'b0;
         req_index <= '0;
         req_arg   <= '0;
         req_rtype <= '0;
      end else begin
         req_valid <= launch;
         stat_lo   <= (stat_lo & ~lo_clr) | lo_set;
         stat_err  <= (stat_err & ~err_clr) | err_set;
         if (reg_wr && hit(reg_addr, OFS_ARG)) arg_q <= reg_wdata;
         if (launch) begin
            cmd_q     <= reg_wdata[13:0];
            req_index <= dec.index;
            req_arg   <= arg_q;
            req_rtype <= dec.rtype;
            cmd_inhib <= 1'b1;
            if (dec.needs_dat) dat_inhib <= 1'b1;
            waiting   <= (dec.rtype != RT_NONE);
            pend_none <= (dec.rtype == RT_NONE);
            crc_q     <= dec.crc_chk;
            idx_q     <= dec.idx_chk;
            long_q    <= (dec.rtype == RT_LONG);
         end
         if (pend_none) begin
            pend_none <= 1'b0;
            cmd_inhib <= 1'b0;
         end
         if (rsp_ok) begin
            waiting   <= 1'b0;
            cmd_inhib <= 1'b0;
         end
         if (lo_set[1]) dat_inhib <= 1'b0;
         if (rst_cmd_act) begin
            cmd_inhib <= 1'b0;
            waiting   <= 1'b0;
            pend_none <= 1'b0;
         end
         if (rst_dat_act) dat_inhib <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if      (hit(reg_raddr, OFS_ARG))  reg_rdata = arg_q;
      else if (hit(reg_raddr, OFS_CMD))  reg_rdata = {18'b0, cmd_q};
      else if (hit(reg_raddr, OFS_RSP0)) reg_rdata = rsp_words[31:0];
      else if (hit(reg_raddr, OFS_RSP1)) reg_rdata = rsp_words[63:32];
      else if (hit(reg_raddr, OFS_RSP2)) reg_rdata = rsp_words[95:64];
      else if (hit(reg_raddr, OFS_RSP3)) reg_rdata = rsp_words[127:96];
      else if (hit(reg_raddr, OFS_PRES)) reg_rdata = {30'b0, dat_inhib, cmd_inhib};
      else if (hit(reg_raddr, OFS_SRST)) reg_rdata = {29'b0, rst_act};
      else if (hit(reg_raddr, OFS_STAT)) reg_rdata = {12'b0, stat_err, |stat_err, 13'b0, stat_lo};
   end

   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);
   assert_issue_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !$past(cmd_inhib));
   assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_err & ~$past(stat_err))) |-> $past(rsp_valid));
   assert_dat_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_inhib) |-> $past(dat_done || rst_dat_act));
   assert_cmd_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_cmd_act |=> !cmd_inhib);
endmodule

// File: tb/sdh_cmd_unit_test.sv
module sdh_cmd_unit_test;
   localparam int HOLD = 4;
   localparam logic [7:0] A_ARG = 8'h08, A_CMD = 8'h0C, A_R0 = 8'h10, A_R1 = 8'h14,
                          A_R2 = 8'h18, A_R3 = 8'h1C, A_PRES = 8'h24, A_SRST = 8'h2C,
                          A_STAT = 8'h30;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_addr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic req_valid;
   logic [5:0] req_index;
   logic [31:0] req_arg;
   logic [1:0] req_rtype;
   logic rsp_valid = 1'b0, rsp_timeout = 1'b0, rsp_crc_err = 1'b0;
   logic rsp_end_err = 1'b0, rsp_idx_err = 1'b0, dat_done = 1'b0;
   logic [127:0] rsp_payload = '0;
   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sdh_cmd_unit #(.ADDR_W(8), .RST_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
      .req_rtype(req_rtype), .rsp_valid(rsp_valid), .rsp_payload(rsp_payload),
      .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
      .rsp_end_err(rsp_end_err), .rsp_idx_err(rsp_idx_err), .dat_done(dat_done)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic issue(input logic [5:0] idx, input logic [7:0] flags);
      wr(A_CMD, {18'b0, idx, flags});
   endtask

   task automatic respond(input logic [127:0] pl, input logic to, input logic crc,
                          input logic eb, input logic ix);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_payload = pl; rsp_timeout = to;
      rsp_crc_err = crc; rsp_end_err = eb; rsp_idx_err = ix;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_crc_err = 1'b0;
      rsp_end_err = 1'b0; rsp_idx_err = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); dat_done = 1'b1;
      @(negedge clk); dat_done = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      rd(A_PRES, d); chk("R1 present", d, 0);
      rd(A_STAT, d); chk("R1 status", d, 0);
      rd(A_R0, d);   chk("R1 resp0", d, 0);
      rd(A_SRST, d); chk("R1 srst", d, 0);
      chk("R1 req_valid", req_valid, 0);
   endtask

   task automatic t_short();
      logic [31:0] d;
      wr(A_ARG, 32'h1234ABCD);
      issue(6'd17, 8'h1A);
      chk("R2 req_valid", req_valid, 1);
      chk("R2 index", req_index, 17);
      chk("R2 arg", req_arg, 32'h1234ABCD);
      chk("R2 rtype", req_rtype, 2'b10);
      rd(A_PRES, d); chk("R2 present", d, 1);
      @(negedge clk); chk("R2 pulse", req_valid, 0);
      issue(6'd5, 8'h02);
      chk("R3 ignored while inhibited", req_valid, 0);
      rd(A_CMD, d); chk("R3 cmd word kept", d, {18'b0, 6'd17, 8'h1A});
      respond({96'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF, 32'hCAFEF00D}, 0, 0, 0, 0);
      rd(A_R0, d); chk("R4 word0", d, 32'hCAFEF00D);
      rd(A_R1, d); chk("R4 word1", d, 0);
      rd(A_R3, d); chk("R4 word3", d, 0);
      rd(A_STAT, d); chk("R4 status", d, 1);
      rd(A_PRES, d); chk("R4 inhibit cleared", d, 0);
      wr(A_STAT, 32'h0000_8001);
      rd(A_STAT, d); chk("R9 w1c", d, 0);
   endtask

   task automatic t_long();
      logic [31:0] d;
      logic [127:0] pl, ex;
      pl = 128'h0123456789ABCDEF_FEDCBA9876543210;
      ex = {8'h00, pl[127:8]};
      issue(6'd2, 8'h09);
      chk("R2 long rtype", req_rtype, 2'b01);
      respond(pl, 0, 0, 0, 0);
      rd(A_R0, d); chk("R5 word0", d, ex[31:0]);
      rd(A_R1, d); chk("R5 word1", d, ex[63:32]);
      rd(A_R2, d); chk("R5 word2", d, ex[95:64]);
      rd(A_R3, d); chk("R5 word3", d, ex[127:96]);
      wr(A_STAT, 32'h1);
   endtask

   task automatic t_noresp();
      logic [31:0] d;
      issue(6'd0, 8'h00);
      chk("R6 request", req_valid, 1);
      rd(A_PRES, d); chk("R6 inhibit set", d, 1);
      @(negedge clk);
      rd(A_PRES, d); chk("R6 inhibit cleared", d, 0);
      rd(A_STAT, d); chk("R6 status", d, 1);
      wr(A_STAT, 32'h1);
   endtask

   task automatic t_errors();
      logic [31:0] d, keep;
      issue(6'd3, 8'h02);
      respond(128'h55, 0, 1, 0, 1);
      rd(A_STAT, d); chk("R7 masked crc/index", d, 1);
      wr(A_STAT, 32'h1);
      rd(A_R0, keep);
      issue(6'd7, 8'h1A);
      respond(128'h77, 0, 1, 1, 0);
      rd(A_STAT, d); chk("R7 crc+end", d, 32'h0006_8000);
      rd(A_PRES, d); chk("R7 inhibit cleared", d, 0);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d); chk("R9 clear errors", d, 0);
      wr(A_STAT, 32'h0000_8000);
      rd(A_STAT, d); chk("R9 bit15 not writable", d, 0);
      rd(A_R0, keep);
      issue(6'd8, 8'h1A);
      respond(128'h99, 1, 1, 1, 1);
      rd(A_STAT, d); chk("R7 timeout only", d, 32'h0001_8000);
      rd(A_R0, d); chk("R7 timeout no capture", d, keep);
      wr(A_STAT, 32'hFFFF_FFFF);
   endtask

   task automatic t_busy();
      logic [31:0] d;
      issue(6'd12, 8'h03);
      rd(A_PRES, d); chk("R2 busy sets both", d, 3);
      respond(128'h1, 0, 0, 0, 0);
      rd(A_PRES, d); chk("R8 data held", d, 2);
      rd(A_STAT, d); chk("R4 busy resp", d, 1);
      wr(A_STAT, 32'h1);
      issue(6'd13, 8'h00);
      chk("R3 non-data issues", req_valid, 1);
      @(negedge clk);
      wr(A_STAT, 32'h1);
      issue(6'd18, 8'h22);
      chk("R3 data cmd gated", req_valid, 0);
      pulse_done();
      rd(A_PRES, d); chk("R8 data released", d, 0);
      rd(A_STAT, d); chk("R8 xfer done", d, 2);
      wr(A_STAT, 32'h2);
      pulse_done();
      rd(A_STAT, d); chk("R8 stray done ignored", d, 0);
   endtask

   task automatic t_srst();
      logic [31:0] d;
      issue(6'd18, 8'h22);
      rd(A_PRES, d); chk("R2 data cmd", d, 3);
      wr(A_SRST, 32'h2);
      rd(A_SRST, d); chk("R10 cmd bit set", d, 2);
      issue(6'd1, 8'h02);
      chk("R10 issue blocked", req_valid, 0);
      repeat (HOLD - 1) @(negedge clk);
      rd(A_SRST, d); chk("R10 cmd bit cleared", d, 0);
      rd(A_PRES, d); chk("R10 cmd inhibit cleared", d, 2);
      respond(128'hF00, 0, 0, 0, 0);
      rd(A_STAT, d); chk("R10 late response dropped", d, 0);
      wr(A_SRST, 32'h4);
      repeat (HOLD) @(negedge clk);
      rd(A_PRES, d); chk("R10 data reset", d, 0);
      rd(A_SRST, d); chk("R10 data bit cleared", d, 0);
      wr(A_ARG, 32'hDEAD_BEEF);
      issue(6'd9, 8'h02);
      respond(128'h4242, 0, 0, 0, 0);
      wr(A_SRST, 32'h1);
      repeat (HOLD) @(negedge clk);
      rd(A_ARG, d);  chk("R10 all arg", d, 0);
      rd(A_R0, d);   chk("R10 all resp", d, 0);
      rd(A_STAT, d); chk("R10 all status", d, 0);
      rd(A_SRST, d); chk("R10 all bit cleared", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_short();
      t_long();
      t_noresp();
      t_errors();
      t_busy();
      t_srst();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule